// File: doc/BRIEF.md
# PCIe Host Address Window Configuration

This block is the register file that a PCIe host bridge uses to place its address windows in the system address map. Six windows are held: a configuration-space window, a message window, three outbound memory windows and a window onto the bridge's local registers. Each window has a 64-bit base that software writes as two 32-bit halves, and a mask. The outbound windows take 64-bit masks in two halves. The other three take 32-bit masks. Two further 32-bit words, a spare word and a control word, are plain storage.

From each mask the block decodes a window size and an enable, and it drives them continuously. Bit 0 of the mask is the enable. The size is the two's complement of the mask with bit 0 cleared. The configuration window's size is capped at a parameterised maximum. The register window treats one specific mask value as a fixed 4 KiB window. A 64-bit probe address is compared against every window at once, which gives one hit flag per window.

Software reaches the block through a 32-bit register port: a write strobe with an offset, and a combinational read-back of the addressed word.

Top module: `pcie_win_cfg`

## Requirements
- R1: Word offsets hold bases as follows: config high 0 and low 1; message high 3 and low 4; outbound window k (k = 0..2) high 6+4k and low 7+4k; register window high 18 and low 19. A write to one half replaces only that half, and the other half keeps its value.
- R2: Masks live at these offsets: config 2, message 5, register window 20, outbound window k high 8+4k and low 9+4k. Every mask word reads back exactly the value last written to it.
- R3: A window is enabled exactly when bit 0 of its mask is 1. `win_en` bit order is: 0 config, 1 message, 2..4 outbound 0..2, 5 register window.
- R4: For the config, message and register windows, size = (~(mask & 0xFFFFFFFE) + 1) computed modulo 2^32 and zero-extended to 64 bits. For the outbound windows the same rule is applied to the full 64-bit mask modulo 2^64. Window i's size is on `win_size[64*i +: 64]`.
- R5: The config window size is capped at CFG_SIZE_MAX (default 0x1000_0000). A mask of 0xE000_0001 gives size 0x1000_0000 with the window enabled.
- R6: A register-window mask of exactly 0x0000_7001 gives size 0x1000 and enable 1. Any other value follows R4.
- R7: Offset 21 (spare) and offset 22 (control) are 32-bit read/write words with no side effects.
- R8: `win_hit[i]` is 1 exactly when window i is enabled and (probe_addr - base) modulo 2^64 is less than its size.
- R9: Reset clears every register to zero. All windows are then disabled with no hits, and every offset reads 0.
- R10: Offsets 23 to 31 read as 0. Writes to them change no state.
- R11: A write takes effect at the clock edge where `reg_we` is sampled high. `reg_rdata`, `win_en`, `win_size` and `win_hit` follow the stored state combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | 5 | Word offset for both read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read-back of the addressed word |
| probe_addr | input | 64 | Address compared against all windows |
| win_en | output | 6 | Per-window enable |
| win_size | output | 384 | Per-window decoded size, 64 bits each |
| win_hit | output | 6 | Per-window hit flag for probe_addr |

## Verification
The size decode is driven with four kinds of mask. A mask with bit 0 clear shows that the size is still computed while the enable stays off. A mask of just 1 produces a zero-size window that never hits. The 0xE000_0001 firmware value separates a correct clamp from the raw 512 MiB size. The fixed 0x7001 value and a near neighbour of it separate the special case from the general rule. Probe addresses one byte below, at the last byte of, and one past the end of a window expose off-by-one and signedness errors in the hit compare. Half-word writes in both orders catch a half that clobbers its partner.

// File: rtl/pcie_win_cfg.sv
module pcie_win_cfg #(
  parameter logic [63:0] CFG_SIZE_MAX   = 64'h0000_0000_1000_0000,
  parameter logic [31:0] REG_FIXED_MASK = 32'h0000_7001,
  parameter logic [63:0] REG_FIXED_SIZE = 64'h0000_0000_0000_1000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_we,
  input  logic [4:0]   reg_addr,
  input  logic [31:0]  reg_wdata,
  output logic [31:0]  reg_rdata,
  input  logic [63:0]  probe_addr,
  output logic [5:0]   win_en,
  output logic [383:0] win_size,
  output logic [5:0]   win_hit
);
  localparam int NWIN  = 6;
  localparam int W_CFG = 0;
  localparam int W_MSG = 1;
  localparam int W_OB0 = 2;
  localparam int W_REG = 5;

  localparam logic [4:0] A_CFG_BH = 5'd0,  A_CFG_BL = 5'd1,  A_CFG_M = 5'd2;
  localparam logic [4:0] A_MSG_BH = 5'd3,  A_MSG_BL = 5'd4,  A_MSG_M = 5'd5;
  localparam logic [4:0] A_OB_BASE = 5'd6;
  localparam logic [4:0] A_REG_BH = 5'd18, A_REG_BL = 5'd19, A_REG_M = 5'd20;
  localparam logic [4:0] A_SPARE  = 5'd21, A_CTRL   = 5'd22;

  logic [63:0] base_q [NWIN];
  logic [63:0] mask_q [NWIN];
  logic [31:0] spare_q, ctrl_q;

  logic       ob_sel;
  logic [1:0] ob_idx;
  logic [1:0] ob_fld;
  logic [4:0] ob_off;

  assign ob_off = reg_addr - A_OB_BASE;
  assign ob_sel = (reg_addr >= A_OB_BASE) && (reg_addr < A_OB_BASE + 5'd12);
  assign ob_idx = ob_off[3:2];
  assign ob_fld = ob_off[1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NWIN; i++) begin
        base_q[i] <= '0;
        mask_q[i] <= '0;
      end
      spare_q <= '0;
      ctrl_q  <= '0;
    end else if (reg_we) begin
      if (ob_sel) begin
        case (ob_fld)
          2'd0: base_q[W_OB0 + int'(ob_idx)][63:32] <= reg_wdata;
          2'd1: base_q[W_OB0 + int'(ob_idx)][31:0]  <= reg_wdata;
          2'd2: mask_q[W_OB0 + int'(ob_idx)][63:32] <= reg_wdata;
          default: mask_q[W_OB0 + int'(ob_idx)][31:0] <= reg_wdata;
        endcase
      end else begin
        case (reg_addr)
          A_CFG_BH: base_q[W_CFG][63:32] <= reg_wdata;
          A_CFG_BL: base_q[W_CFG][31:0]  <= reg_wdata;
          A_CFG_M:  mask_q[W_CFG][31:0]  <= reg_wdata;
          A_MSG_BH: base_q[W_MSG][63:32] <= reg_wdata;
          A_MSG_BL: base_q[W_MSG][31:0]  <= reg_wdata;
          A_MSG_M:  mask_q[W_MSG][31:0]  <= reg_wdata;
          A_REG_BH: base_q[W_REG][63:32] <= reg_wdata;
          A_REG_BL: base_q[W_REG][31:0]  <= reg_wdata;
          A_REG_M:  mask_q[W_REG][31:0]  <= reg_wdata;
          A_SPARE:  spare_q <= reg_wdata;
          A_CTRL:   ctrl_q  <= reg_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (ob_sel) begin
      case (ob_fld)
        2'd0: reg_rdata = base_q[W_OB0 + int'(ob_idx)][63:32];
        2'd1: reg_rdata = base_q[W_OB0 + int'(ob_idx)][31:0];
        2'd2: reg_rdata = mask_q[W_OB0 + int'(ob_idx)][63:32];
        default: reg_rdata = mask_q[W_OB0 + int'(ob_idx)][31:0];
      endcase
    end else begin
      case (reg_addr)
        A_CFG_BH: reg_rdata = base_q[W_CFG][63:32];
        A_CFG_BL: reg_rdata = base_q[W_CFG][31:0];
        A_CFG_M:  reg_rdata = mask_q[W_CFG][31:0];
        A_MSG_BH: reg_rdata = base_q[W_MSG][63:32];
        A_MSG_BL: reg_rdata = base_q[W_MSG][31:0];
        A_MSG_M:  reg_rdata = mask_q[W_MSG][31:0];
        A_REG_BH: reg_rdata = base_q[W_REG][63:32];
        A_REG_BL: reg_rdata = base_q[W_REG][31:0];
        A_REG_M:  reg_rdata = mask_q[W_REG][31:0];
        A_SPARE:  reg_rdata = spare_q;
        A_CTRL:   reg_rdata = ctrl_q;
        default:  reg_rdata = '0;
      endcase
    end
  end

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    logic [63:0] raw, sz;
    if (i >= W_OB0 && i < W_REG) begin : g_wide
      assign raw = ~(mask_q[i] & ~64'd1) + 64'd1;
    end else begin : g_narrow
      logic [31:0] r32;
      assign r32 = ~(mask_q[i][31:0] & ~32'd1) + 32'd1;
      assign raw = {32'd0, r32};
    end
    if (i == W_CFG) begin : g_clamp
      assign sz = (raw > CFG_SIZE_MAX) ? CFG_SIZE_MAX : raw;
    end else if (i == W_REG) begin : g_fixed
      assign sz = (mask_q[i][31:0] == REG_FIXED_MASK) ? REG_FIXED_SIZE : raw;
    end else begin : g_plain
      assign sz = raw;
    end
    assign win_size[64*i +: 64] = sz;
    assign win_en[i]  = mask_q[i][0];
    assign win_hit[i] = mask_q[i][0] && ((probe_addr - base_q[i]) < sz);
  end
endmodule

module pcie_win_cfg_chk #(
  parameter logic [63:0] CFG_SIZE_MAX = 64'h0000_0000_1000_0000
) (
  input logic         clk,
  input logic         rst_n,
  input logic         reg_we,
  input logic [4:0]   reg_addr,
  input logic [31:0]  reg_wdata,
  input logic [5:0]   win_en,
  input logic [383:0] win_size,
  input logic [5:0]   win_hit
);
  AST_EN_FOLLOWS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 5'd2) |=> (win_en[0] == $past(reg_wdata[0]))); // R3
  AST_CFG_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    win_size[63:0] <= CFG_SIZE_MAX); // R5
  AST_REG_FIXED_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 5'd20 && reg_wdata == 32'h0000_7001)
      |=> (win_size[5*64 +: 64] == 64'h1000 && win_en[5])); // R6
  AST_HIT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (win_hit & ~win_en) == 6'd0); // R8
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (win_en == 6'd0 && win_hit == 6'd0)); // R9
  AST_UNMAPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr > 5'd22) |=> ($stable(win_en) && $stable(win_size))); // R10
endmodule

bind pcie_win_cfg pcie_win_cfg_chk #(.CFG_SIZE_MAX(CFG_SIZE_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .win_en(win_en), .win_size(win_size), .win_hit(win_hit)
);

// File: tb/sim_pcie_win_cfg.sv
module sim_pcie_win_cfg;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_we = 1'b0;
  logic [4:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic [63:0]  probe_addr = '0;
  logic [5:0]   win_en;
  logic [383:0] win_size;
  logic [5:0]   win_hit;

  int n_chk = 0;
  int n_bad = 0;

  pcie_win_cfg u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .probe_addr(probe_addr),
    .win_en(win_en), .win_size(win_size), .win_hit(win_hit)
  );

  always #10 clk = ~clk;

  // addr, write data, expected read-back
  localparam int NV = 14;
  localparam logic [68:0] VEC [NV] = '{
    {5'd0,  32'h0000_0001, 32'h0000_0001},
    {5'd1,  32'h2000_0000, 32'h2000_0000},
    {5'd6,  32'hDEAD_BEEF, 32'hDEAD_BEEF},
    {5'd7,  32'h0000_1000, 32'h0000_1000},
    {5'd8,  32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {5'd9,  32'hFFFF_0001, 32'hFFFF_0001},
    {5'd21, 32'hA5A5_5A5A, 32'hA5A5_5A5A},
    {5'd22, 32'h1234_5678, 32'h1234_5678},
    {5'd23, 32'hFFFF_FFFF, 32'h0000_0000},
    {5'd31, 32'hFFFF_FFFF, 32'h0000_0000},
    {5'd5,  32'hFFFF_F001, 32'hFFFF_F001},
    {5'd20, 32'h0000_7001, 32'h0000_7001},
    {5'd3,  32'h0000_0000, 32'h0000_0000},
    {5'd4,  32'h8000_0000, 32'h8000_0000}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  function automatic logic [63:0] sz(input int i);
    return win_size[64*i +: 64];
  endfunction

  task automatic probe(input logic [63:0] a);
    probe_addr = a;
    #1;
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    logic [5:0]  en_before;
    logic [383:0] sz_before;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    chk("R9 en after reset", {58'd0, win_en}, 64'd0);
    probe(64'd0);
    chk("R9 hit after reset", {58'd0, win_hit}, 64'd0);
    rd(5'd2, r);  chk("R9 cfg mask reads 0", {32'd0, r}, 64'd0);

    // table walk: write then read back (R1 R2 R7 R10 R11)
    for (int v = 0; v < NV; v++) begin
      logic [4:0] a;
      string req;
      a = VEC[v][68:64];
      wr(a, VEC[v][63:32]);
      rd(a, r);
      if (a > 5'd22) req = "R10 unmapped";
      else if (a == 5'd21 || a == 5'd22) req = "R7 storage";
      else if (a == 5'd2 || a == 5'd5 || a == 5'd20 || (a >= 5'd6 && a <= 5'd17 && a[1] == 1'b0)) req = "R2 mask";
      else req = "R1 base";
      chk(req, {32'd0, r}, {32'd0, VEC[v][31:0]});
    end

    // R1 other half kept
    rd(5'd0, r);  chk("R1 cfg high kept", {32'd0, r}, 64'h1);
    rd(5'd6, r);  chk("R1 ob0 high kept", {32'd0, r}, 64'hDEAD_BEEF);
    rd(5'd8, r);  chk("R2 ob0 mask high kept", {32'd0, r}, 64'hFFFF_FFFF);

    // R4 64-bit outbound size and R8 boundaries
    chk("R3 ob0 enabled", {63'd0, win_en[2]}, 64'd1);
    chk("R4 ob0 size", sz(2), 64'h1_0000);
    probe(64'hDEAD_BEEF_0001_0FFF); chk("R8 ob0 last byte hits", {63'd0, win_hit[2]}, 64'd1);
    probe(64'hDEAD_BEEF_0001_1000); chk("R8 ob0 past end", {63'd0, win_hit[2]}, 64'd0);
    probe(64'hDEAD_BEEF_0000_0FFF); chk("R8 ob0 below base", {63'd0, win_hit[2]}, 64'd0);

    // R4 32-bit message window
    chk("R4 msg size", sz(1), 64'h1000);
    probe(64'h0000_0000_8000_0FFF); chk("R8 msg hit", {63'd0, win_hit[1]}, 64'd1);

    // R6 fixed register-window size
    chk("R6 reg size 0x7001", sz(5), 64'h1000);
    chk("R6 reg enabled", {63'd0, win_en[5]}, 64'd1);
    probe(64'h0000_0000_0000_0FFF); chk("R8 reg hit", {63'd0, win_hit[5]}, 64'd1);
    wr(5'd20, 32'hFFFF_7001);
    chk("R6 neighbour value follows R4", sz(5), 64'h9000);

    // R5 clamp with firmware value
    chk("R3 cfg disabled with mask 0", {63'd0, win_en[0]}, 64'd0);
    wr(5'd2, 32'hE000_0001);
    chk("R5 cfg clamped size", sz(0), 64'h1000_0000);
    chk("R5 cfg enabled", {63'd0, win_en[0]}, 64'd1);
    probe(64'h0000_0001_2FFF_FFFF); chk("R8 cfg last byte", {63'd0, win_hit[0]}, 64'd1);
    probe(64'h0000_0001_3000_0000); chk("R8 cfg past end", {63'd0, win_hit[0]}, 64'd0);

    // R3 enable bit clear: size still computed, no hit
    wr(5'd2, 32'hFFF0_0000);
    chk("R3 cfg off", {63'd0, win_en[0]}, 64'd0);
    chk("R4 cfg size while off", sz(0), 64'h10_0000);
    probe(64'h0000_0001_2000_0010); chk("R8 no hit when off", {63'd0, win_hit[0]}, 64'd0);

    // R4 zero-size window from mask 1
    wr(5'd17, 32'h0000_0001);
    chk("R4 ob2 zero size", sz(4), 64'd0);
    probe(64'd0); chk("R8 zero size never hits", {63'd0, win_hit[4]}, 64'd0);

    // R10 unmapped write leaves decode untouched
    en_before = win_en; sz_before = win_size;
    wr(5'd27, 32'hFFFF_FFFF);
    chk("R10 en unchanged", {58'd0, win_en}, {58'd0, en_before});
    chk("R10 sizes unchanged", {63'd0, win_size == sz_before}, 64'd1);

    // R9 reset again
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk("R9 en cleared", {58'd0, win_en}, 64'd0);
    rd(5'd22, r); chk("R9 ctrl cleared", {32'd0, r}, 64'd0);
    rd(5'd7, r);  chk("R9 ob0 base cleared", {32'd0, r}, 64'd0);

    finish_run();
  end
endmodule